// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block is an I2C target that holds a small bank of eight-bit control registers. The default is twenty registers, at register numbers 0x00 to 0x13. A controller on the bus can write any number of bytes from a chosen starting register. It can read from wherever the internal pointer currently stands. It can also set the pointer with a short write and then, after a repeated START, read from that register onward. All registers are presented in parallel on a flat output vector, so the surrounding logic sees every setting at once.

A single pointer serves both directions. It moves forward by one after every data byte, whether that byte was received or sent. After the last register it returns to register 0. A read with no sub-address therefore picks up one past the previous access of either kind. The bus pins are sampled through synchronizers. SDA is driven open-drain through an enable that pulls the line low when set.

Top module: `i2cRegTarget`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal TARGET_ADDR (default 0x1A), for either value of the R/W bit (bit 0, 1 = read). Any other address gets no acknowledge. The target then leaves SDA released and changes no register until the next START.
- R2: In a write transfer, the byte after the address loads the pointer. Each later byte is stored in the register at the pointer, and the pointer then advances by one. The target acknowledges every one of these bytes.
- R3: The pointer steps from the last register (NUM_REGS-1) to 0. A write burst that runs past the top overwrites register 0 and the registers above it. A read burst that runs past the top wraps the same way.
- R4: A write holding only a sub-address, followed by a repeated START and a read address, returns data starting at that sub-address. A repeated START in the middle of a byte discards the partial byte.
- R5: A read with no preceding sub-address returns the register one past the last one accessed, whether that access was a read or a write.
- R6: Read data leaves MSB first. After each byte the controller acknowledges, the next register follows. After a byte the controller does not acknowledge, the target releases SDA. It does not drive SDA after a STOP.
- R7: The SDA enable changes only while the synchronized SCL is low, apart from the release forced by a START or STOP.
- R8: After reset the pointer is 0, every register holds its slice of REG_INIT (register i in bits 8i+7..8i), and SDA is released.
- R9: A sub-address above NUM_REGS-1 sets the pointer to register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bus is oversampled against it |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| regFlat | output | NUM_REGS*8 | All registers, register i in bits 8i+7..8i |

## Verification
The assertions take several things for granted. Each level on SCL and SDA is held for more clocks than the synchronizer depth plus one. SDA from the controller changes only while SCL is low, except when it forms a START or STOP. A bit cell therefore produces exactly one rising and one falling edge on the synchronized clock. The stimulus drives the bus in quarter-bit steps of eight system clocks, changes controller data a full quarter after SCL falls, and samples halfway through SCL high. This leaves the target several clocks to settle its own SDA drive inside every low phase.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_AW,
    ST_ACK_AR,
    ST_SUB,
    ST_ACK_W,
    ST_WDATA,
    ST_RDATA,
    ST_MACK
  } busState_t;

  // strobes from control to datapath, each one clock wide
  typedef struct packed {
    logic       ptrLoad;
    logic       regWrite;
    logic       txLoad;
    logic       txShift;
    logic [7:0] rxByte;
  } dpStrobe_t;

endpackage

// File: rtl/bitSync.sv
module bitSync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2cTargetCtrl.sv
module i2cTargetCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h1A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      txBit,
  output dpStrobe_t strobe,
  output logic      sdaOe
);
  logic sclS, sdaS, sclPrev, sdaPrev;

  bitSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  bitSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic startDet, stopDet, sclRise, sclFall;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;

  busState_t  state;
  logic [2:0] bitCnt;
  logic [7:0] rxShift;
  logic       gotByte, ackDrive, txEn, mAck;
  logic       rxState;

  assign rxState = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_WDATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= 3'd0;
      rxShift  <= 8'd0;
      gotByte  <= 1'b0;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
      mAck     <= 1'b0;
    end else if (startDet || stopDet) begin
      state    <= startDet ? ST_ADDR : ST_IDLE;
      bitCnt   <= 3'd0;
      gotByte  <= 1'b0;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
    end else begin
      if (sclRise) begin
        if (rxState) begin
          rxShift <= {rxShift[6:0], sdaS};
          bitCnt  <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) gotByte <= 1'b1;
        end
        if (state == ST_MACK) mAck <= !sdaS;
      end
      if (sclFall) begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (gotByte) begin
              gotByte <= 1'b0;
              if (state == ST_ADDR) begin
                if (rxShift[7:1] == TARGET_ADDR) begin
                  ackDrive <= 1'b1;
                  state    <= rxShift[0] ? ST_ACK_AR : ST_ACK_AW;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                ackDrive <= 1'b1;
                state    <= ST_ACK_W;
              end
            end
          end
          ST_ACK_AW: begin
            ackDrive <= 1'b0;
            bitCnt   <= 3'd0;
            state    <= ST_SUB;
          end
          ST_ACK_W: begin
            ackDrive <= 1'b0;
            bitCnt   <= 3'd0;
            state    <= ST_WDATA;
          end
          ST_ACK_AR: begin
            ackDrive <= 1'b0;
            txEn     <= 1'b1;
            bitCnt   <= 3'd0;
            state    <= ST_RDATA;
          end
          ST_RDATA: begin
            if (bitCnt == 3'd7) begin
              txEn  <= 1'b0;
              state <= ST_MACK;
            end else begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
          ST_MACK: begin
            if (mAck) begin
              txEn   <= 1'b1;
              bitCnt <= 3'd0;
              state  <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic busEvent;
  assign busEvent = startDet || stopDet;

  always_comb begin
    strobe          = '0;
    strobe.rxByte   = rxShift;
    strobe.ptrLoad  = !busEvent && sclFall && gotByte && (state == ST_SUB);
    strobe.regWrite = !busEvent && sclFall && gotByte && (state == ST_WDATA);
    strobe.txLoad   = !busEvent && sclFall &&
                      ((state == ST_ACK_AR) || ((state == ST_MACK) && mAck));
    strobe.txShift  = !busEvent && sclFall && (state == ST_RDATA) && (bitCnt != 3'd7);
  end

  assign sdaOe = ackDrive || (txEn && !txBit);

  // R7: drive changes land only in SCL-low phases
  a_r7_sda_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(busEvent)) |-> !$past(sclS));

  // R1: an acknowledge is raised only for the matching address
  a_r1_ack_match: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ackDrive) && $past(state) == ST_ADDR) |-> ($past(rxShift[7:1]) == TARGET_ADDR));

  // R6: SDA is free once a STOP has been seen
  a_r6_release_stop: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> !sdaOe);

  // R1: idle target never drives the line
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  // R2: at most one datapath action per cycle
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ptrLoad, strobe.regWrite, strobe.txLoad, strobe.txShift}));
endmodule

// File: rtl/i2cTargetData.sv
module i2cTargetData
  import i2cRegPkg::*;
#(
  parameter int                    NUM_REGS = 20,
  parameter logic [NUM_REGS*8-1:0] REG_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] regFlat
);
  localparam int               PTR_W   = $clog2(NUM_REGS);
  localparam logic [PTR_W-1:0] LAST    = PTR_W'(NUM_REGS - 1);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
  localparam logic [7:0]       LAST_B  = 8'(NUM_REGS - 1);

  logic [7:0]       regs [NUM_REGS];
  logic [PTR_W-1:0] ptr, ptrNext;
  logic [7:0]       txShiftReg;

  assign ptrNext = (ptr == LAST) ? '0 : ptr + PTR_ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= REG_INIT[i*8 +: 8];
      ptr        <= '0;
      txShiftReg <= 8'd0;
    end else begin
      if (strobe.ptrLoad) begin
        ptr <= (strobe.rxByte <= LAST_B) ? strobe.rxByte[PTR_W-1:0] : '0;
      end
      if (strobe.regWrite) begin
        regs[ptr] <= strobe.rxByte;
        ptr       <= ptrNext;
      end
      if (strobe.txLoad) begin
        txShiftReg <= regs[ptr];
        ptr        <= ptrNext;
      end
      if (strobe.txShift) txShiftReg <= {txShiftReg[6:0], 1'b0};
    end
  end

  assign txBit = txShiftReg[7];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gFlat
    assign regFlat[g*8 +: 8] = regs[g];
  end

  // R3: pointer stays in the register range
  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= LAST);

  // R3: stepping past the top lands on register 0
  a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (($past(strobe.regWrite) || $past(strobe.txLoad)) && $past(ptr) == LAST) |-> (ptr == '0));

  // R2: a received data byte lands where the pointer stood
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.regWrite) |-> (regs[$past(ptr)] == $past(strobe.rxByte)));

  // R2: the bank holds without a write strobe
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.regWrite) |-> $stable(regFlat));
endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cRegPkg::*;
#(
  parameter logic [6:0]            TARGET_ADDR = 7'h1A,
  parameter int                    NUM_REGS    = 20,
  parameter logic [NUM_REGS*8-1:0] REG_INIT    = '0,
  parameter int                    SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regFlat
);
  dpStrobe_t strobe;
  logic      txBit;

  i2cTargetCtrl #(.TARGET_ADDR(TARGET_ADDR), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .txBit(txBit), .strobe(strobe), .sdaOe(sdaOe));

  i2cTargetData #(.NUM_REGS(NUM_REGS), .REG_INIT(REG_INIT)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txBit(txBit), .regFlat(regFlat));
endmodule

// File: tb/tb_i2cRegTarget.sv
module tb_i2cRegTarget;
  localparam int         NREG = 20;
  localparam logic [6:0] DEV  = 7'h1A;
  localparam int         Q    = 8;

  function automatic logic [NREG*8-1:0] mkInit();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = 8'(8'h30 + 3 * i);
    return v;
  endfunction
  localparam logic [NREG*8-1:0] INIT = mkInit();

  // sub-address, data byte
  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h135A, 16'h0A3C,
                                      16'h07C3, 16'h1F99, 16'hFF42};

  logic clk = 1'b0, rstN = 1'b0, mScl = 1'b1, mSda = 1'b1;
  logic sdaOe;
  logic [NREG*8-1:0] regFlat;
  wire  sdaLine = mSda & ~sdaOe;

  always #10 clk = ~clk;

  i2cRegTarget #(.TARGET_ADDR(DEV), .NUM_REGS(NREG), .REG_INIT(INIT)) dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .regFlat(regFlat));

  int checks = 0, fails = 0, r7Bad = 0;
  logic prevOe = 1'b0;
  logic [7:0] mdl [NREG];

  always @(negedge clk) begin
    if (rstN && (sdaOe !== prevOe) && mScl) r7Bad++;
    prevOe = sdaOe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startBus();
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b0; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic stopBus();
    mSda = 1'b0; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b1; waitQ();
  endtask

  task automatic clockBit(input logic v, output logic s);
    mSda = v; waitQ(); mScl = 1'b1; waitQ(); s = sdaLine; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(~ackIt, s);
    mSda = 1'b1;
  endtask

  task automatic setPtr(input logic [7:0] sub, input string req);
    logic a;
    startBus();
    writeByte({DEV, 1'b0}, a); check(req, a, 1);
    writeByte(sub, a);         check(req, a, 1);
  endtask

  task automatic readOne(input string req, input logic [7:0] exp);
    logic a;
    logic [7:0] d;
    startBus();
    writeByte({DEV, 1'b1}, a); check(req, a, 1);
    readByte(1'b0, d);
    stopBus();
    check(req, d, exp);
  endtask

  task automatic checkBank(input string req);
    for (int i = 0; i < NREG; i++) check(req, regFlat[i*8 +: 8], mdl[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) mdl[i] = INIT[i*8 +: 8];
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R8: reset state
    check("R8 bank", regFlat, INIT);
    check("R8 sda", sdaOe, 0);
    // R8/R5: pointer starts at register 0
    readOne("R8 ptr", mdl[0]);

    // R2 R4 R9: vector table, single write then random read
    for (int k = 0; k < 6; k++) begin
      logic [7:0] sub, dat;
      int idx;
      sub = VEC[k][15:8];
      dat = VEC[k][7:0];
      idx = (sub > 8'(NREG - 1)) ? 0 : int'(sub);
      setPtr(sub, "R2");
      writeByte(dat, a); check("R2 data ack", a, 1);
      stopBus();
      mdl[idx] = dat;
      check(idx == 0 && sub != 0 ? "R9 write" : "R2 write", regFlat[idx*8 +: 8], dat);
      setPtr(sub, "R4");
      readOne("R4 random read", dat);
    end

    // R3: write burst across the top
    setPtr(8'h12, "R3");
    writeByte(8'h11, a); check("R3 ack", a, 1);
    writeByte(8'h22, a); check("R3 ack", a, 1);
    writeByte(8'h33, a); check("R3 ack", a, 1);
    stopBus();
    mdl[18] = 8'h11; mdl[19] = 8'h22; mdl[0] = 8'h33;
    checkBank("R3 wrap write");

    // R5: current read after a write continues at last+1
    readOne("R5 after write", mdl[1]);

    // R6 R3: read burst across the top, MSB first, NACK ends it
    setPtr(8'h11, "R6");
    startBus();
    writeByte({DEV, 1'b1}, a); check("R6 addr", a, 1);
    readByte(1'b1, d); check("R6 byte0", d, mdl[17]);
    readByte(1'b1, d); check("R6 byte1", d, mdl[18]);
    readByte(1'b1, d); check("R3 byte2", d, mdl[19]);
    readByte(1'b0, d); check("R3 wrap read", d, mdl[0]);
    stopBus();
    waitQ();
    check("R6 released", sdaOe, 0);

    // R5: current read after a read continues at last+1
    readOne("R5 after read", mdl[1]);

    // R1: foreign address is ignored
    startBus();
    writeByte({7'h2B, 1'b0}, a); check("R1 nack write", a, 0);
    writeByte(8'h04, a);
    writeByte(8'hEE, a);
    stopBus();
    checkBank("R1 bank untouched");
    startBus();
    writeByte({7'h2B, 1'b1}, a); check("R1 nack read", a, 0);
    readByte(1'b0, d); check("R1 line free", d, 8'hFF);
    stopBus();

    // R4: repeated start inside a data byte drops the partial byte
    setPtr(8'h05, "R4");
    clockBit(1'b0, a); clockBit(1'b1, a); clockBit(1'b0, a);
    startBus();
    writeByte({DEV, 1'b1}, a); check("R4 restart addr", a, 1);
    readByte(1'b0, d);
    stopBus();
    check("R4 abort read", d, mdl[5]);
    checkBank("R4 abort bank");

    // R7: SDA drive moved only while SCL was low
    check("R7 drive timing", r7Bad, 0);

    summary();
    $finish;
  end
endmodule